// File: doc/BRIEF.md
# Paged Memory Write Guard

This block sits between the bus masters and a physical memory of up to 1M words. It checks every access against three pieces of programmed state. The first two are write-protect maps with one bit per 1K-word page, one map for processor-initiated accesses and one for DMA-initiated accesses. The third is a map of which 64K-word blocks of memory are actually fitted. A write to a protected page is stopped: the block withholds the memory write enable and raises a one-cycle protect fault. An access to a block that is not fitted, or an I/O access outside the legal I/O range, raises an address-error flag to the processor. Each of these two address checks can be switched on or off.

All state is loaded through a write-only register port. A select field picks the target: one of the two page maps, the block map, or the check-enable register. An index then picks a 16-bit word of the chosen page map. Every output is registered and appears in the clock cycle after the access is presented.

Top module: `pageWriteGuard`

## Requirements
- R1: The page index is accAddr[19:10]. A valid memory write (accIsIo=0) by the CPU (accIsDma=0) to a page whose CPU-map bit is 1 gives memWrEn=0 and protFault=1 in the next cycle.
- R2: A valid memory write with accIsDma=1 is judged only by the DMA map. The CPU map has no effect on it, and the DMA map has no effect on CPU writes.
- R3: Reads (accWrite=0) are never blocked by either page map and never raise protFault.
- R4: A valid memory write to an unprotected page in an implemented block gives memWrEn=1 in the next cycle, with protFault=0 and addrErr=0.
- R5: With cfgLoad=1, cfgSel=0 loads the CPU map and cfgSel=1 loads the DMA map. cfgIdx selects the word, and bit i of cfgData sets the protect bit of page cfgIdx*16+i (1 means protected).
- R6: cfgSel=2 loads the block map from cfgData[15:0], where bit b stands for the block with accAddr[19:16]=b and a 1 means the block is fitted. When unfitted-block checking is on, a valid memory read or write to an unfitted block gives addrErr=1 in the next cycle, and such a write gives memWrEn=0.
- R7: When I/O checking is on, a valid access with accIsIo=1 and accAddr[19:16] not zero gives addrErr=1. An I/O access never gives memWrEn=1 or protFault=1.
- R8: cfgSel=3 loads the check enables. cfgData[0] switches on unfitted-block checking and cfgData[1] switches on I/O checking. When unfitted-block checking is off, a write to an unfitted block goes through with memWrEn=1 and addrErr=0.
- R9: After reset, every protect bit is 0, every block is fitted, both checks are on, and all outputs are 0.
- R10: A load takes effect from the next cycle on. An access presented in the same cycle as a load is judged by the old state.
- R11: A cycle with accValid=0 gives memWrEn=0, protFault=0 and addrErr=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accIsDma | input | 1 | 1 when the DMA is the master, 0 when the CPU is |
| accIsIo | input | 1 | 1 for an I/O access, 0 for a memory access |
| accAddr | input | 20 | Physical word address |
| cfgLoad | input | 1 | Load strobe for the register port |
| cfgSel | input | 2 | Load target: 0 CPU map, 1 DMA map, 2 block map, 3 check enables |
| cfgIdx | input | 6 | Word index within a page map |
| cfgData | input | 16 | Load data |
| memWrEn | output | 1 | Memory write enable, one cycle after the access |
| protFault | output | 1 | Pulse for a blocked write |
| addrErr | output | 1 | Pulse for an unfitted-block access or an illegal I/O access |

## Verification
The hardest case to reach from the ports is a load and an access in the same cycle that touch the same page bit. The stimulus presents a CPU write to page 2 in the very cycle that sets that page's protect bit, and expects the write to go through. It then repeats the write and expects it to be blocked. The other hard cases are the page bits at the ends of the index range: bit 15 of the last map word, which is page 1023, and its neighbour page 1022. The stimulus sets the DMA map so that page 1023 differs from the CPU map at that page and from the DMA map at page 1022. A fault in the index arithmetic or in the choice of map then shows up as a wrong memWrEn.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [1:0] {
    SEL_CPU_MAP = 2'd0,
    SEL_DMA_MAP = 2'd1,
    SEL_BLK_MAP = 2'd2,
    SEL_ENABLES = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic ldCpu;
    logic ldDma;
    logic ldBlk;
  } loadStb_t;

endpackage

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_OFF_W = 10,
  parameter int BLK_OFF_W  = 16,
  parameter int MAP_W      = 16,
  localparam int PAGE_W    = ADDR_W - PAGE_OFF_W,
  localparam int BIT_W     = $clog2(MAP_W),
  localparam int IDX_W     = PAGE_W - BIT_W,
  localparam int WORDS     = 1 << IDX_W,
  localparam int BLK_W     = ADDR_W - BLK_OFF_W,
  localparam int NUM_BLKS  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadStb_t          stb,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [MAP_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              cpuProt,
  output logic              dmaProt,
  output logic              blkFitted
);

  logic [PAGE_W-1:0] pageIdx;
  logic [IDX_W-1:0]  wordSel;
  logic [BIT_W-1:0]  bitSel;
  logic [BLK_W-1:0]  blkSel;
  logic [1:0]        mapLoad;
  logic [1:0]        protBits;
  logic [NUM_BLKS-1:0] blkMap;

  assign pageIdx = accAddr[ADDR_W-1:PAGE_OFF_W];
  assign wordSel = pageIdx[PAGE_W-1:BIT_W];
  assign bitSel  = pageIdx[BIT_W-1:0];
  assign blkSel  = accAddr[ADDR_W-1:BLK_OFF_W];
  assign mapLoad = {stb.ldDma, stb.ldCpu};

  // One protect map per master type: index 0 is the CPU map, index 1 the DMA map
  for (genvar m = 0; m < 2; m++) begin : g_map
    logic [MAP_W-1:0] words [WORDS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) words[w] <= '0;
      end else if (mapLoad[m]) begin
        words[cfgIdx] <= cfgData;
      end
    end
    assign protBits[m] = words[wordSel][bitSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          blkMap <= '1;
    else if (stb.ldBlk) blkMap <= cfgData[NUM_BLKS-1:0];
  end

  assign cpuProt   = protBits[0];
  assign dmaProt   = protBits[1];
  assign blkFitted = blkMap[blkSel];

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldCpu, stb.ldDma, stb.ldBlk})); // R5

  AST_BLK_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldBlk |=> (blkMap == $past(cfgData[NUM_BLKS-1:0]))); // R6

endmodule

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BLK_OFF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accIsDma,
  input  logic              accIsIo,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgSel,
  input  logic [1:0]        cfgEnBits,
  input  logic              cpuProt,
  input  logic              dmaProt,
  input  logic              blkFitted,
  output loadStb_t          stb,
  output logic              memWrEn,
  output logic              protFault,
  output logic              addrErr
);

  logic chkUnfit;
  logic chkIo;
  logic isMemAcc;
  logic isMemWr;
  logic protHit;
  logic unfitHit;
  logic ioHit;
  logic selProt;

  // Decode of the register port into load strobes for the datapath
  always_comb begin
    stb = '0;
    if (cfgLoad) begin
      unique case (cfgSel_e'(cfgSel))
        SEL_CPU_MAP: stb.ldCpu = 1'b1;
        SEL_DMA_MAP: stb.ldDma = 1'b1;
        SEL_BLK_MAP: stb.ldBlk = 1'b1;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkUnfit <= 1'b1;
      chkIo    <= 1'b1;
    end else if (cfgLoad && cfgSel_e'(cfgSel) == SEL_ENABLES) begin
      chkUnfit <= cfgEnBits[0];
      chkIo    <= cfgEnBits[1];
    end
  end

  assign selProt  = accIsDma ? dmaProt : cpuProt;
  assign isMemAcc = accValid && !accIsIo;
  assign isMemWr  = isMemAcc && accWrite;
  assign protHit  = isMemWr && selProt;
  assign unfitHit = chkUnfit && isMemAcc && !blkFitted;
  assign ioHit    = chkIo && accValid && accIsIo && (accAddr[ADDR_W-1:BLK_OFF_W] != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      protFault <= 1'b0;
      addrErr   <= 1'b0;
    end else begin
      memWrEn   <= isMemWr && !selProt && !unfitHit;
      protFault <= protHit;
      addrErr   <= unfitHit || ioHit;
    end
  end

  AST_FAULT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> !memWrEn); // R1

  AST_READ_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite) |=> !protFault); // R3

  AST_WRITE_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(accValid && accWrite && !accIsIo)); // R4

  AST_IO_NO_MEMORY: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsIo) |=> (!memWrEn && !protFault)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!memWrEn && !protFault && !addrErr)); // R11

endmodule

// File: rtl/pageWriteGuard.sv
module pageWriteGuard
  import wpg_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_OFF_W = 10,
  parameter int BLK_OFF_W  = 16,
  parameter int MAP_W      = 16,
  localparam int IDX_W     = ADDR_W - PAGE_OFF_W - $clog2(MAP_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accIsDma,
  input  logic              accIsIo,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [MAP_W-1:0]  cfgData,
  output logic              memWrEn,
  output logic              protFault,
  output logic              addrErr
);

  loadStb_t stb;
  logic cpuProt;
  logic dmaProt;
  logic blkFitted;

  wpg_ctrl #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accWrite(accWrite), .accIsDma(accIsDma),
    .accIsIo(accIsIo), .accAddr(accAddr),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgEnBits(cfgData[1:0]),
    .cpuProt(cpuProt), .dmaProt(dmaProt), .blkFitted(blkFitted),
    .stb(stb),
    .memWrEn(memWrEn), .protFault(protFault), .addrErr(addrErr)
  );

  wpg_datapath #(
    .ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W),
    .BLK_OFF_W(BLK_OFF_W), .MAP_W(MAP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .stb(stb), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .accAddr(accAddr),
    .cpuProt(cpuProt), .dmaProt(dmaProt), .blkFitted(blkFitted)
  );

endmodule

// File: tb/pageWriteGuard_tb.sv
module pageWriteGuard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, accIsDma = 1'b0, accIsIo = 1'b0;
  logic [19:0] accAddr = '0;
  logic cfgLoad = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [5:0] cfgIdx = '0;
  logic [15:0] cfgData = '0;
  logic memWrEn, protFault, addrErr;

  pageWriteGuard u_dut (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accWrite(accWrite), .accIsDma(accIsDma),
    .accIsIo(accIsIo), .accAddr(accAddr),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .memWrEn(memWrEn), .protFault(protFault), .addrErr(addrErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic  we;
    logic  pf;
    logic  er;
    int    cyc;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference state written from the requirements
  bit cpuM [1024];
  bit dmaM [1024];
  bit blkM [16];
  bit enUnfit = 1;
  bit enIo = 1;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: present one cycle of stimulus and queue the expected result
  task automatic step(input logic v, input logic w, input logic dma, input logic io,
                      input logic [19:0] a, input logic ld, input logic [1:0] sel,
                      input logic [5:0] idx, input logic [15:0] d, input string tag);
    exp_t e;
    bit pb, unfit, ioBad;
    @(negedge clk);
    accValid = v; accWrite = w; accIsDma = dma; accIsIo = io; accAddr = a;
    cfgLoad = ld; cfgSel = sel; cfgIdx = idx; cfgData = d;
    pb    = dma ? dmaM[a[19:10]] : cpuM[a[19:10]];
    unfit = enUnfit && v && !io && !blkM[a[19:16]];
    ioBad = enIo && v && io && (a[19:16] != 4'd0);
    e.we  = v && w && !io && !pb && !unfit;
    e.pf  = v && w && !io && pb;
    e.er  = unfit || ioBad;
    e.cyc = cyc;
    e.tag = tag;
    expQ.push_back(e);
    if (ld) begin
      case (sel)
        2'd0: for (int i = 0; i < 16; i++) cpuM[idx*16+i] = d[i];
        2'd1: for (int i = 0; i < 16; i++) dmaM[idx*16+i] = d[i];
        2'd2: for (int i = 0; i < 16; i++) blkM[i] = d[i];
        default: begin enUnfit = d[0]; enIo = d[1]; end
      endcase
    end
  endtask

  task automatic acc(input logic w, input logic dma, input logic io,
                     input logic [19:0] a, input string tag);
    step(1'b1, w, dma, io, a, 1'b0, 2'd0, 6'd0, 16'd0, tag);
  endtask

  task automatic load(input logic [1:0] sel, input logic [5:0] idx,
                      input logic [15:0] d, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 20'd0, 1'b1, sel, idx, d, tag);
  endtask

  // Monitor: compare each queued item one cycle after it was presented
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].cyc < cyc) begin
      exp_t e;
      e = expQ.pop_front();
      compared++;
      if (memWrEn !== e.we || protFault !== e.pf || addrErr !== e.er) begin
        mismatched++;
        $display("FAIL %s: actual we=%b pf=%b er=%b expected we=%b pf=%b er=%b",
                 e.tag, memWrEn, protFault, addrErr, e.we, e.pf, e.er);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) blkM[i] = 1;
    repeat (3) @(negedge clk);
    compared++;
    if (memWrEn !== 1'b0 || protFault !== 1'b0 || addrErr !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 reset outputs: actual %b%b%b expected 000", memWrEn, protFault, addrErr);
    end
    rstN = 1'b1;

    // R9 / R4: everything open after reset
    acc(1, 0, 0, 20'h00400, "R9 cpu write after reset");
    acc(1, 1, 0, 20'hFFC00, "R9 dma write after reset");
    acc(0, 0, 0, 20'hF0000, "R9 read all blocks fitted");

    // R5 / R1: protect page 1 in the CPU map
    load(2'd0, 6'd0, 16'h0002, "R11 idle during load");
    acc(1, 0, 0, 20'h00400, "R1 cpu write protected page 1");
    acc(1, 0, 0, 20'h007FF, "R1 last word of page 1");
    acc(1, 0, 0, 20'h003FF, "R4 cpu write page 0");
    acc(0, 0, 0, 20'h00400, "R3 cpu read protected page");
    acc(1, 1, 0, 20'h00400, "R2 dma ignores cpu map");

    // R5 / R2: page 1023 protected for DMA only
    load(2'd1, 6'd63, 16'h8000, "R5 load dma map word 63");
    acc(1, 1, 0, 20'hFFC00, "R2 dma write page 1023 blocked");
    acc(1, 0, 0, 20'hFFC00, "R2 cpu write page 1023 allowed");
    acc(1, 1, 0, 20'hFF800, "R5 dma write page 1022 allowed");
    acc(0, 1, 0, 20'hFFC00, "R3 dma read page 1023");

    // R10: load and access in the same cycle
    step(1, 1, 0, 0, 20'h00800, 1'b1, 2'd0, 6'd0, 16'h0006, "R10 same-cycle old map");
    acc(1, 0, 0, 20'h00800, "R10 next cycle new map");

    // R6: block 2 unfitted
    load(2'd2, 6'd0, 16'hFFFB, "R6 load block map");
    acc(0, 0, 0, 20'h20000, "R6 read unfitted block");
    acc(1, 0, 0, 20'h23456, "R6 write unfitted block");
    acc(1, 0, 0, 20'h30000, "R6 write fitted block 3");

    // R7: I/O checks
    acc(1, 0, 1, 20'h10000, "R7 illegal io write");
    acc(0, 0, 1, 20'h00100, "R7 legal io read");
    acc(1, 0, 1, 20'h00400, "R7 io to protected page no fault");

    // R8: check enables
    load(2'd3, 6'd0, 16'h0000, "R8 disable checks");
    acc(1, 0, 0, 20'h20000, "R8 unfitted write with check off");
    acc(1, 0, 1, 20'h10000, "R8 io with check off");
    load(2'd3, 6'd0, 16'h0001, "R8 unfit check only");
    acc(1, 0, 0, 20'h20000, "R8 unfitted write check on");
    acc(1, 0, 1, 20'h10000, "R8 io still off");

    // R11: idle cycle with protected address on the bus
    step(0, 1, 0, 0, 20'h00400, 1'b0, 2'd0, 6'd0, 16'd0, "R11 idle with write bits set");
    acc(1, 0, 0, 20'h00C00, "R4 cpu write page 3");

    @(negedge clk);
    accValid = 1'b0; cfgLoad = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule